// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add Unit

This block computes X×Y+Z on three binary32 operands and rounds only once. It forms the 48-bit product of the two significands exactly and aligns the addend against that product. The product and the addend are then added or subtracted, the sum is normalized, and a single round-to-nearest-even step produces the packed result. Because the product is never rounded on its own, a sum whose leading bits cancel still keeps the low product bits. Those bits appear in the result, where a separate multiply followed by an add would return zero or a badly truncated value.

The unit accepts one operand triple per clock, qualified by `in_valid`. The result is registered and appears with `out_valid` one cycle later. Subnormal encodings are treated as zeros on input and are never produced on output. NaN handling is reduced to one canonical quiet NaN and a single invalid-operation bit.

Top module: `fma32_unit`

## Requirements
- R1: For finite nonzero operands the result equals the exact real value of X×Y+Z rounded once to nearest-even in binary32 (sign bit 31, 8-bit exponent field bits 30:23 with bias 127, 23-bit fraction bits 22:0 with an implied leading one). It is never the value obtained by rounding the product first.
- R2: When the addend nearly cancels the product, normalization recovers the low product bits. For example, 0x3F800001 × 0x3F800001 + 0xBF800002 gives exactly 0x28800000 (2^-46).
- R3: A sum lying exactly halfway between two representable values rounds to the one with an even fraction LSB. Any nonzero bit below the halfway point rounds away from the truncated value.
- R4: The addend is aligned by exponent difference. When it lies far below the product it contributes only a sticky bit, and when it lies far above the product the product contributes only a sticky bit. Both cases still give the correctly rounded result.
- R5: An exact zero sum of two nonzero terms of opposite sign gives +0 (0x00000000). When the product is zero and the addend is zero, the result is -0 only if both zero terms are negative, and +0 otherwise. A zero product with a nonzero addend returns the addend unchanged.
- R6: Infinity times zero, and an infinite product added to an infinite addend of opposite sign, both give 0x7FC00000 with `out_invalid` = 1. Every other result has `out_invalid` = 0.
- R7: Any NaN operand (exponent field 255, nonzero fraction) gives 0x7FC00000 with `out_invalid` = 0. This takes priority over every other rule.
- R8: An infinite product (with no zero factor) gives infinity with sign X⊕Y. Otherwise an infinite addend gives that infinity.
- R9: A rounded result whose biased exponent reaches 255 or above gives infinity (exponent 255, fraction 0) with the result's sign.
- R10: An operand with exponent field 0 is treated as a zero of its sign. A rounded result whose biased exponent is 0 or below becomes a zero with the result's sign, so the output never has exponent field 0 with a nonzero fraction.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The synchronous active-low reset clears `out_valid`, `out_result` and `out_invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand triple present this cycle |
| in_x | input | 32 | Multiplicand, binary32 |
| in_y | input | 32 | Multiplier, binary32 |
| in_z | input | 32 | Addend, binary32 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Rounded X×Y+Z, binary32 |
| out_invalid | output | 1 | Invalid-operation indication for the current result |

## Verification
The hardest situation to reach from the ports is deep cancellation: an addend of opposite sign whose significand matches the top 24 bits of the exact product, so the sum collapses by twenty or more binades. Uniform random operands almost never land there. The stimulus therefore builds the addend from the product's upper bits, with the same exponent and only a few low bits perturbed. A second stream forces large exponent gaps both ways to drive the sticky-only alignment paths. Every vector is compared with an exact wide-integer model of the sum.

// File: rtl/fma32_pkg.sv
// Package: shared widths, derived frame geometry and the decoded operand
// type used by every stage of the fused multiply-add datapath.
package fma32_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int BIAS    = 127;
    localparam int N_OPS   = 3;

    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    // Addend LSB position in the frame when no right shift is applied.
    localparam int Z_LSB   = PROD_W + 3;
    // Frame: jam bit 0, product, addend, plus one carry bit on top.
    localparam int FRAME_W = Z_LSB + SIG_W + 1;
    localparam int LZ_W    = $clog2(FRAME_W);
    localparam int SE_W    = EXP_W + 4;
    localparam int EXP_ALL = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              zero;
        logic              inf;
        logic              nan;
    } opnd_t;
endpackage

// File: rtl/fma32_decode.sv
// Operand decoder: splits one binary32 word into sign, exponent and
// significand with the hidden one, and classifies it.
// Assumes flush-to-zero: an exponent field of 0 is a zero of its sign.
module fma32_decode
    import fma32_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    output opnd_t             op
);
    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;

    // Field split and class flags.
    always_comb begin
        e_fld   = raw[WORD_W-2 -: EXP_W];
        f_fld   = raw[FRAC_W-1:0];
        op.sign = raw[WORD_W-1];
        op.exp  = e_fld;
        op.zero = (e_fld == '0);
        op.inf  = (e_fld == '1) && (f_fld == '0);
        op.nan  = (e_fld == '1) && (f_fld != '0);
        op.sig  = op.zero ? '0 : {1'b1, f_fld};
    end
endmodule

// File: rtl/fma32_align_add.sv
// Product, alignment and addition stage.
// Forms the exact PROD_W-bit significand product, places it and the addend
// in a FRAME_W-bit fixed-point frame whose bit 0 is a jam (sticky) bit,
// and adds or subtracts the magnitudes. Also gives the biased exponent
// that the sum would have if its leading one sat at the frame MSB.
// Assumes finite, nonzero multiplicands; special cases are chosen upstream.
module fma32_align_add
    import fma32_pkg::*;
(
    input  opnd_t                   a,
    input  opnd_t                   b,
    input  opnd_t                   c,
    output logic [FRAME_W-1:0]      sum,
    output logic                    sum_sign,
    output logic signed [SE_W-1:0]  exp_top
);
    logic [PROD_W-1:0]      prod;
    logic signed [SE_W-1:0] ea, eb, ec, diff, rsh;
    logic [FRAME_W-1:0]     z_wide, p_al, c_al;
    logic [LZ_W-1:0]        sh;
    logic                   c_st, big_c, p_sign, sub;

    // Full-width product, never rounded.
    assign prod = a.sig * b.sig;

    assign ea = $signed({{(SE_W-EXP_W){1'b0}}, a.exp});
    assign eb = $signed({{(SE_W-EXP_W){1'b0}}, b.exp});
    assign ec = $signed({{(SE_W-EXP_W){1'b0}}, c.exp});

    // Exponent gap between addend LSB and product LSB, and right shift.
    always_comb begin
        diff  = ec - ea - eb + SE_W'(BIAS + FRAC_W);
        rsh   = SE_W'(Z_LSB - 1) - diff;
        big_c = !c.zero && (rsh < SE_W'(0));
    end

    // Alignment of both terms into the frame, with jam bits.
    always_comb begin
        z_wide = {1'b0, c.sig, {Z_LSB{1'b0}}};
        sh     = '0;
        c_st   = 1'b0;
        if (big_c) begin
            c_al    = z_wide;
            p_al    = FRAME_W'(1);
            exp_top = ec + SE_W'(FRAME_W - 1 - FRAC_W - Z_LSB);
        end else begin
            p_al    = FRAME_W'({prod, 1'b0});
            exp_top = ea + eb + SE_W'(FRAME_W - 2 - BIAS - 2 * FRAC_W);
            if (rsh >= SE_W'(FRAME_W)) begin
                c_al = '0;
                c_st = !c.zero;
            end else begin
                sh   = rsh[LZ_W-1:0];
                c_al = z_wide >> sh;
                c_st = |(z_wide & ~({FRAME_W{1'b1}} << sh));
            end
            c_al[0] = c_al[0] | c_st;
        end
    end

    // Magnitude add or subtract; larger term gives the sign.
    always_comb begin
        p_sign = a.sign ^ b.sign;
        sub    = p_sign != c.sign;
        if (!sub) begin
            sum      = p_al + c_al;
            sum_sign = p_sign;
        end else if (p_al >= c_al) begin
            sum      = p_al - c_al;
            sum_sign = p_sign;
        end else begin
            sum      = c_al - p_al;
            sum_sign = c.sign;
        end
    end

    // A far-larger addend leaves the product as a lone jam bit (R4).
    always_comb begin
        if (big_c) p_jam_only_r4: assert (p_al == FRAME_W'(1) && c_al[FRAME_W-2]);
    end
endmodule

// File: rtl/fma32_norm_round.sv
// Normalize, round once to nearest-even, and pack.
// Counts leading zeros of the frame sum, shifts left so the leading one
// sits at the frame MSB, rounds on guard and sticky, then handles overflow
// to infinity and flush-to-zero below the smallest normal.
// Assumes the sum is an unsigned magnitude; a zero sum packs as +0.
module fma32_norm_round
    import fma32_pkg::*;
(
    input  logic [FRAME_W-1:0]      sum,
    input  logic                    sum_sign,
    input  logic signed [SE_W-1:0]  exp_top,
    output logic [WORD_W-1:0]       res
);
    logic [LZ_W-1:0]        lz;
    logic [FRAME_W-1:0]     norm;
    logic [SIG_W-1:0]       mant;
    logic [SIG_W:0]         rnd;
    logic                   guard, sticky, inc;
    logic signed [SE_W-1:0] exp_f;

    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (sum[i]) lz = LZ_W'(FRAME_W - 1 - i);
        end
    end

    // Normalizing left shift and round-to-nearest-even.
    always_comb begin
        norm   = sum << lz;
        mant   = norm[FRAME_W-1 -: SIG_W];
        guard  = norm[FRAME_W-1-SIG_W];
        sticky = |norm[FRAME_W-2-SIG_W:0];
        inc    = guard & (sticky | mant[0]);
        rnd    = {1'b0, mant} + (SIG_W+1)'(inc);
        exp_f  = exp_top - $signed({{(SE_W-LZ_W){1'b0}}, lz})
                 + $signed({{(SE_W-1){1'b0}}, rnd[SIG_W]});
    end

    // Packing with overflow and flush-to-zero.
    always_comb begin
        if (sum == '0)
            res = '0;
        else if (exp_f >= SE_W'(EXP_ALL))
            res = {sum_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (exp_f <= SE_W'(0))
            res = {sum_sign, {(EXP_W+FRAC_W){1'b0}}};
        else
            res = {sum_sign, exp_f[EXP_W-1:0], rnd[FRAC_W-1:0]};
    end

    // The shifter must place the leading one at the frame MSB (R1, R2).
    always_comb begin
        if (sum != '0) p_norm_lead_r1: assert (norm[FRAME_W-1]);
    end
endmodule

// File: rtl/fma32_unit.sv
// Single-precision fused multiply-add, one output register.
// Decodes three operands, resolves NaN, invalid, infinity and zero-product
// cases, and otherwise takes the single-rounded finite result.
// Assumes flush-to-zero on inputs and outputs and round-to-nearest-even.
module fma32_unit
    import fma32_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_x,
    input  logic [WORD_W-1:0] in_y,
    input  logic [WORD_W-1:0] in_z,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid
);
    logic [WORD_W-1:0]      raw [N_OPS];
    opnd_t                  ops [N_OPS];
    logic [FRAME_W-1:0]     sum;
    logic                   sum_sign;
    logic signed [SE_W-1:0] exp_top;
    logic [WORD_W-1:0]      fin_res, nxt_res;
    logic                   nxt_inv;
    logic                   nan_any, p_inf, p_zero, p_sign;

    assign raw[0] = in_x;
    assign raw[1] = in_y;
    assign raw[2] = in_z;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_dec
        fma32_decode u_dec (
            .raw (raw[gi]),
            .op  (ops[gi])
        );
    end

    fma32_align_add u_add (
        .a        (ops[0]),
        .b        (ops[1]),
        .c        (ops[2]),
        .sum      (sum),
        .sum_sign (sum_sign),
        .exp_top  (exp_top)
    );

    fma32_norm_round u_rnd (
        .sum      (sum),
        .sum_sign (sum_sign),
        .exp_top  (exp_top),
        .res      (fin_res)
    );

    // Special-case priority: NaN, invalid, infinities, zero product, finite.
    always_comb begin
        nan_any = ops[0].nan | ops[1].nan | ops[2].nan;
        p_inf   = ops[0].inf | ops[1].inf;
        p_zero  = ops[0].zero | ops[1].zero;
        p_sign  = ops[0].sign ^ ops[1].sign;
        nxt_inv = !nan_any && ((p_inf && p_zero) ||
                  (p_inf && ops[2].inf && (p_sign != ops[2].sign)));
        if (nan_any || nxt_inv)
            nxt_res = QNAN;
        else if (p_inf)
            nxt_res = {p_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (ops[2].inf)
            nxt_res = {ops[2].sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (p_zero && ops[2].zero)
            nxt_res = {p_sign & ops[2].sign, {(EXP_W+FRAC_W){1'b0}}};
        else if (p_zero)
            nxt_res = in_z;
        else
            nxt_res = fin_res;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt_res;
                out_invalid <= nxt_inv;
            end
        end
    end

    p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_invalid_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == QNAN));
    p_canon_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_result[WORD_W-2 -: EXP_W]) && (|out_result[FRAC_W-1:0]))
        |-> (out_result == QNAN));
    p_no_denorm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_result[WORD_W-2 -: EXP_W] == '0))
        |-> (out_result[FRAC_W-1:0] == '0));
endmodule

// File: tb/fma32_unit_bench.sv
`timescale 1ns/1ps
module fma32_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_x = '0, in_y = '0, in_z = '0;
    logic        out_valid, out_invalid;
    logic [31:0] out_result;
    int          n_chk = 0;
    int          n_bad = 0;

    fma32_unit u_fma32_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid)
    );

    always #10 clk = ~clk;

    // Exact model: wide-integer sum, one rounding, then range handling.
    function automatic logic [32:0] ref_fma(input logic [31:0] x, y, z);
        logic sx, sy, sz, sp, s, g, st;
        logic [7:0] ex, ey, ez;
        logic [22:0] fx, fy, fz;
        logic xz, yz, zz, xi, yi, zi, nan_in;
        logic [47:0] p;
        logic [511:0] bp, bz, mag, mask, one;
        logic [24:0] m;
        int ep, ezl, emin, msb, e;
        {sx, ex, fx} = x; {sy, ey, fy} = y; {sz, ez, fz} = z;
        xz = ex == 0; yz = ey == 0; zz = ez == 0;
        xi = ex == 8'hFF && fx == 0; yi = ey == 8'hFF && fy == 0; zi = ez == 8'hFF && fz == 0;
        nan_in = (ex == 8'hFF && fx != 0) || (ey == 8'hFF && fy != 0) || (ez == 8'hFF && fz != 0);
        sp = sx ^ sy;
        if (nan_in) return {1'b0, 32'h7FC00000};
        if ((xi || yi) && (xz || yz)) return {1'b1, 32'h7FC00000};
        if ((xi || yi) && zi && sp != sz) return {1'b1, 32'h7FC00000};
        if (xi || yi) return {1'b0, sp, 8'hFF, 23'h0};
        if (zi) return {1'b0, sz, 8'hFF, 23'h0};
        if (xz || yz) begin
            if (zz) return {1'b0, sp & sz, 31'h0};
            return {1'b0, z};
        end
        p = {1'b1, fx} * {1'b1, fy};
        ep = int'(ex) + int'(ey) - 300;
        ezl = int'(ez) - 150;
        emin = (zz || ep < ezl) ? ep : ezl;
        bp = 512'(p) << (ep - emin);
        bz = zz ? '0 : (512'({1'b1, fz}) << (ezl - emin));
        if (sp == sz) begin mag = bp + bz; s = sp; end
        else if (bp >= bz) begin mag = bp - bz; s = sp; end
        else begin mag = bz - bp; s = sz; end
        if (mag == 0) return 33'h0;
        msb = 0;
        for (int i = 0; i < 512; i++) if (mag[i]) msb = i;
        one = 512'd1;
        if (msb >= 24) begin
            m = 25'(mag >> (msb - 23));
            g = mag[msb-24];
            mask = (one << (msb - 24)) - one;
            st = |(mag & mask);
        end else begin
            m = 25'(mag << (23 - msb));
            g = 1'b0; st = 1'b0;
        end
        if (g && (st || m[0])) m = m + 25'd1;
        e = emin + msb + 127;
        if (m[24]) begin e = e + 1; m = m >> 1; end
        if (e >= 255) return {1'b0, s, 8'hFF, 23'h0};
        if (e <= 0) return {1'b0, s, 31'h0};
        return {1'b0, s, 8'(e), m[22:0]};
    endfunction

    task automatic apply(input string tag, input logic [31:0] x, y, z, input logic [32:0] ex);
        @(negedge clk);
        in_x = x; in_y = y; in_z = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_chk++;
        if (out_valid !== 1'b1 || out_result !== ex[31:0] || out_invalid !== ex[32]) begin
            n_bad++;
            $display("FAIL %s x=%h y=%h z=%h actual v=%b r=%h i=%b expected v=1 r=%h i=%b",
                     tag, x, y, z, out_valid, out_result, out_invalid, ex[31:0], ex[32]);
        end
    endtask

    task automatic run_ref(input string tag, input logic [31:0] x, y, z);
        apply(tag, x, y, z, ref_fma(x, y, z));
    endtask

    task automatic run_fix(input string tag, input logic [31:0] x, y, z, r, input logic i);
        apply(tag, x, y, z, {i, r});
    endtask

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        int ec;
        ec = e < 1 ? 1 : (e > 254 ? 254 : e);
        return {s, 8'(ec), f};
    endfunction

    function automatic logic [31:0] special_or(input logic [31:0] v);
        case ($urandom_range(0, 7))
            0: return {1'($urandom_range(0, 1)), 31'h0};
            1: return {1'($urandom_range(0, 1)), 8'hFF, 23'h0};
            2: return {1'b0, 8'hFF, 23'($urandom_range(1, 4095))};
            3: return {1'($urandom_range(0, 1)), 8'h00, 23'($urandom_range(1, 8388607))};
            default: return v;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] x, y, z;
        logic [47:0] pp;
        int ex, ey, mode, ez;
        void'($urandom(32'd20250117));
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state with in_valid held high during reset.
        n_chk++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_invalid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset actual v=%b r=%h i=%b expected v=0 r=0 i=0",
                     out_valid, out_result, out_invalid);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed cases.
        run_fix("R1 1*1+1", 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h40000000, 1'b0);
        run_fix("R2 cancel", 32'h3F800001, 32'h3F800001, 32'hBF800002, 32'h28800000, 1'b0);
        run_fix("R3 tie up", 32'h3F800001, 32'h3FC00000, 32'h00000000, 32'h3FC00002, 1'b0);
        run_fix("R3 tie down", 32'h3F800003, 32'h3FC00000, 32'h00000000, 32'h3FC00004, 1'b0);
        run_fix("R3 tie small", 32'h3F800001, 32'h3F400000, 32'h00000000, 32'h3F400002, 1'b0);
        run_fix("R4 big z", 32'h2B800000, 32'h2B800000, 32'h3F800000, 32'h3F800000, 1'b0);
        run_fix("R4 big z sub", 32'h2B800000, 32'h2B800000, 32'hBF800000, 32'hBF800000, 1'b0);
        run_ref("R4 near half ulp", 32'hB3000000, 32'h3FC00000, 32'h3F800000);
        run_fix("R4 tiny z", 32'h3F800000, 32'h3F800000, 32'h0B800000, 32'h3F800000, 1'b0);
        run_fix("R5 exact cancel", 32'h40000000, 32'h40400000, 32'hC0C00000, 32'h00000000, 1'b0);
        run_fix("R5 neg zeros", 32'h80000000, 32'h3F800000, 32'h80000000, 32'h80000000, 1'b0);
        run_fix("R5 mixed zeros", 32'h80000000, 32'h3F800000, 32'h00000000, 32'h00000000, 1'b0);
        run_fix("R5 zero prod", 32'h00000000, 32'h40000000, 32'hC1200000, 32'hC1200000, 1'b0);
        run_fix("R6 inf*0", 32'h7F800000, 32'h00000000, 32'h3F800000, 32'h7FC00000, 1'b1);
        run_fix("R6 inf-inf", 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7FC00000, 1'b1);
        run_fix("R7 nan", 32'h7FC12345, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 1'b0);
        run_fix("R7 nan over inv", 32'h7F800000, 32'h00000000, 32'h7F800001, 32'h7FC00000, 1'b0);
        run_fix("R8 inf prod", 32'h7F800000, 32'hBF800000, 32'h3F800000, 32'hFF800000, 1'b0);
        run_fix("R8 inf z", 32'h3F800000, 32'h3F800000, 32'hFF800000, 32'hFF800000, 1'b0);
        run_fix("R9 overflow", 32'h7F000000, 32'h40000000, 32'h00000000, 32'h7F800000, 1'b0);
        run_fix("R9 neg overflow", 32'hFF000000, 32'h40000000, 32'h3F800000, 32'hFF800000, 1'b0);
        run_fix("R10 min normal", 32'h20000000, 32'h20000000, 32'h00000000, 32'h00800000, 1'b0);
        run_fix("R10 underflow", 32'h9F800000, 32'h1F800000, 32'h00000000, 32'h80000000, 1'b0);
        run_fix("R10 sub in", 32'h00000001, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0);
        run_fix("R10 sub zero", 32'h00400000, 32'h3F800000, 32'h80000000, 32'h00000000, 1'b0);

        // R11: no result the cycle after an idle cycle.
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 idle actual v=%b expected v=0", out_valid);
        end

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            mode = $urandom_range(0, 3);
            ex = $urandom_range(90, 160);
            ey = $urandom_range(90, 160);
            x = mk(1'($urandom_range(0, 1)), ex, 23'($urandom));
            y = mk(1'($urandom_range(0, 1)), ey, 23'($urandom));
            case (mode)
                0: begin
                    z = mk(1'($urandom_range(0, 1)), $urandom_range(80, 170), 23'($urandom));
                    run_ref("R1 random", x, y, z);
                end
                1: begin
                    pp = {1'b1, x[22:0]} * {1'b1, y[22:0]};
                    ez = ex + ey - 127 + int'(pp[47]);
                    z = mk(~(x[31] ^ y[31]), ez,
                           (pp[47] ? pp[46:24] : pp[45:23]) ^ 23'($urandom_range(0, 15)));
                    run_ref("R2 cancel random", x, y, z);
                end
                2: begin
                    ez = ex + ey - 127 + int'($urandom_range(0, 160)) - 80;
                    z = mk(1'($urandom_range(0, 1)), ez, 23'($urandom));
                    run_ref("R4 gap random", x, y, z);
                end
                default: begin
                    z = mk(1'($urandom_range(0, 1)), ex + ey - 127, 23'($urandom));
                    run_ref("R8 special random", special_or(x), special_or(y), special_or(z));
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule